// File: doc/BRIEF.md
# Programmable setpoint slew ramp controller

This block generates the 7-bit reference code that sets the output of a digitally controlled step-down regulator. Each code step is 6.25 mV above a 0.600 V floor, so codes 0 to 127 span 0.600 V to 1.39375 V. Two stored target codes are held outside the block. A select pin decides which one is active. The same pin, together with a 2-bit mode field, decides whether the converter runs in Auto PFM/PWM or Forced PWM.

Moves toward a higher target are ramped one LSB at a time. The interval between steps is set by a 3-bit slew field: setting 0 is fastest, at about 64 mV/µs, and each higher setting doubles the interval. Moves toward a lower target are not ramped. The code drops to the new target at once, and switching is held off until an external comparator reports that the output has discharged to that level. The block flags a rising transition in progress, which includes soft-start from code 0 when the regulator is enabled, and a falling transition in progress.

Top module: `slew_ramp_ctrl`

## Requirements
- R1: While `run` is low, and after reset, `ref_code` is 0 and `switch_enable`, `pos_flag` and `neg_flag` are all low from the next clock on.
- R2: The target is `setpt0` when `sel` is 0 and `setpt1` when `sel` is 1.
- R3: On an upward move, `ref_code` rises by exactly one per step and never passes the target.
- R4: The step interval is BASE_TICKS << `slew` clock cycles. BASE_TICKS is round(97656 ps / CLK_PERIOD_PS), with a minimum of 1. So `slew`=000 is fastest, and each increment doubles the interval.
- R5: When the target is below `ref_code` while running, `ref_code` equals that target on the next clock. From that clock `neg_flag` is high and `switch_enable` is low.
- R6: While waiting, an `out_reached`=1 seen at a clock edge with `ref_code` equal to the target clears `neg_flag` and restores `switch_enable` on that edge. At any other time, `out_reached` has no effect on any output.
- R7: `pos_flag` is high exactly when `run` is high and `ref_code` is below the target. This covers the soft-start ramp from 0 after `run` rises.
- R8: `force_pwm` is `mode[0]` when `sel`=0 and `mode[1]` when `sel`=1. A value of 1 means Forced PWM and 0 means Auto PFM/PWM.
- R9: A target change in mid-move restarts from the present `ref_code`, and the direction is decided again. A higher target during a downward wait ends the wait and starts a ramp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Regulator enabled (hardware and software enable combined) |
| sel | input | 1 | Setpoint and mode select pin |
| setpt0 | input | 7 | Target code used when sel is low |
| setpt1 | input | 7 | Target code used when sel is high |
| slew | input | 3 | Upward ramp rate select |
| mode | input | 2 | Mode bits: bit 0 is used when sel is low, bit 1 when sel is high |
| out_reached | input | 1 | Comparator: output has fallen to the lowered target |
| ref_code | output | 7 | Reference code to the DAC |
| switch_enable | output | 1 | Modulator may switch |
| pos_flag | output | 1 | Upward transition or soft-start in progress |
| neg_flag | output | 1 | Downward transition in progress |
| force_pwm | output | 1 | 1 selects Forced PWM, 0 selects Auto PFM/PWM |

## Verification
Two pairs of events can fall on the same clock edge.

The first pair is a ramp step and a target change. The bench watches for a code step and then moves the setpoint so that the change lands on the edge where the next step is due. The result is judged against a behavioural model that decides direction from the code held before that edge.

The second pair is the jump to a lower target and a comparator report. The bench raises `out_reached` in the same cycle as a downward jump, where it must be ignored. It then raises it again once the code sits at the target, where it must end the wait.

// File: rtl/slew_ramp_ctrl.sv
module slew_ramp_ctrl #(
  parameter int CODE_W        = 7,
  parameter int SLEW_W        = 3,
  parameter int CLK_PERIOD_PS = 10000,
  parameter int FAST_STEP_PS  = 97656
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              sel,
  input  logic [CODE_W-1:0] setpt0,
  input  logic [CODE_W-1:0] setpt1,
  input  logic [SLEW_W-1:0] slew,
  input  logic [1:0]        mode,
  input  logic              out_reached,
  output logic [CODE_W-1:0] ref_code,
  output logic              switch_enable,
  output logic              pos_flag,
  output logic              neg_flag,
  output logic              force_pwm
);

  localparam int RAW_TICKS  = (FAST_STEP_PS + CLK_PERIOD_PS / 2) / CLK_PERIOD_PS;
  localparam int BASE_TICKS = (RAW_TICKS < 1) ? 1 : RAW_TICKS;
  localparam int MAX_TICKS  = BASE_TICKS << ((1 << SLEW_W) - 1);
  localparam int CNT_W      = $clog2(MAX_TICKS + 1);

  logic [CODE_W-1:0] ref_q, target;
  logic [CNT_W-1:0]  cnt_q, step_ticks;
  logic              wait_q;

  assign target     = sel ? setpt1 : setpt0;
  assign step_ticks = CNT_W'(BASE_TICKS) << slew;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q  <= '0;
      cnt_q  <= '0;
      wait_q <= 1'b0;
    end else if (!run) begin
      ref_q  <= '0;
      cnt_q  <= '0;
      wait_q <= 1'b0;
    end else if (target > ref_q) begin
      wait_q <= 1'b0;
      if (cnt_q >= step_ticks - 1'b1) begin
        ref_q <= ref_q + 1'b1;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else if (target < ref_q) begin
      ref_q  <= target;
      cnt_q  <= '0;
      wait_q <= 1'b1;
    end else begin
      cnt_q <= '0;
      if (out_reached) wait_q <= 1'b0;
    end
  end

  assign ref_code      = ref_q;
  assign neg_flag      = wait_q;
  assign switch_enable = run & ~wait_q;
  assign pos_flag      = run & (ref_q < target);
  assign force_pwm     = sel ? mode[1] : mode[0];

  AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (ref_q == '0 && !wait_q)); // R1

  AST_SINGLE_LSB_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_q > $past(ref_q)) |-> (ref_q == $past(ref_q) + 1'b1)); // R3

  AST_NO_OVERSHOOT: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_q > $past(ref_q)) |-> (ref_q <= $past(target))); // R3

  AST_DOWN_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && target < ref_q) |=> (ref_q == $past(target) && wait_q)); // R5

  AST_WAIT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (run && wait_q && out_reached && ref_q == target) |=> !wait_q); // R6

endmodule

// File: tb/slew_ramp_ctrl_tb_top.sv
`timescale 1ns/1ps
module slew_ramp_ctrl_tb_top;
  localparam int CLK_NS   = 10;
  localparam int CLK_PS   = CLK_NS * 1000;
  localparam int BASE     = ((97656 + CLK_PS / 2) / CLK_PS < 1) ? 1 : (97656 + CLK_PS / 2) / CLK_PS;
  localparam int WATCHDOG = 150000;

  logic clk = 0, rst_n = 0, run = 0, sel = 0, out_reached = 0;
  logic [6:0] setpt0 = 0, setpt1 = 0;
  logic [2:0] slew = 0;
  logic [1:0] mode = 0;
  logic [6:0] ref_code;
  logic switch_enable, pos_flag, neg_flag, force_pwm;

  int n_checks = 0, n_fail = 0;
  bit finished = 0;

  int m_ref = 0, m_cnt = 0;
  bit m_wait = 0;

  always #(CLK_NS/2) clk = ~clk;

  slew_ramp_ctrl #(.CLK_PERIOD_PS(CLK_PS)) dut_i (
    .clk(clk), .rst_n(rst_n), .run(run), .sel(sel), .setpt0(setpt0), .setpt1(setpt1),
    .slew(slew), .mode(mode), .out_reached(out_reached), .ref_code(ref_code),
    .switch_enable(switch_enable), .pos_flag(pos_flag), .neg_flag(neg_flag), .force_pwm(force_pwm));

  function automatic int tgt();
    return sel ? int'(setpt1) : int'(setpt0);
  endfunction

  // behavioural reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ref = 0; m_cnt = 0; m_wait = 0;
    end else if (!run) begin
      m_ref = 0; m_cnt = 0; m_wait = 0;
    end else if (tgt() > m_ref) begin
      m_wait = 0;
      if (m_cnt + 1 >= (BASE * (1 << slew))) begin m_ref = m_ref + 1; m_cnt = 0; end
      else m_cnt = m_cnt + 1;
    end else if (tgt() < m_ref) begin
      m_ref = tgt(); m_cnt = 0; m_wait = 1;
    end else begin
      m_cnt = 0;
      if (out_reached) m_wait = 0;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check("R2/R3/R5/R9 ref_code", ref_code, m_ref);
      check("R5/R6 neg_flag", neg_flag, m_wait);
      check("R1/R5/R6 switch_enable", switch_enable, run && !m_wait);
      check("R7 pos_flag", pos_flag, run && (m_ref < tgt()));
      check("R8 force_pwm", force_pwm, sel ? mode[1] : mode[0]);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wait_ref(input int v);
    while (ref_code != 7'(v)) cyc(1);
  endtask

  // R4: cycles between consecutive steps
  task automatic measure(input int exp_ticks);
    logic [6:0] prev;
    int n;
    @(negedge clk); prev = ref_code;
    while (ref_code == prev) @(negedge clk);
    prev = ref_code; n = 0;
    while (ref_code == prev) begin @(negedge clk); n++; end
    check("R4 step interval", n, exp_ticks);
    #2;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(WATCHDOG * CLK_NS);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    cyc(3);
    check("R1 reset ref_code", ref_code, 0);
    check("R1 reset flags", {switch_enable, pos_flag, neg_flag}, 0);
    rst_n = 1;
    setpt0 = 20; setpt1 = 40; slew = 0; mode = 2'b10;
    cyc(5);                                     // R1 idle with run low
    check("R1 idle ref_code", ref_code, 0);
    run = 1;                                    // R7 soft-start
    cyc(1);
    check("R7 soft-start pos_flag", pos_flag, 1);
    measure(BASE);                              // R4 slew 0
    wait_ref(20);
    cyc(2);
    out_reached = 1; cyc(3); out_reached = 0;   // R6 ignored when not waiting
    check("R6 ignored switch_enable", switch_enable, 1);
    sel = 1; slew = 2;                          // R2 R8
    measure(BASE * 4);                          // R4 slew 2
    wait_ref(25);
    cyc(BASE * 4 - 1);                          // change near a step edge (R9)
    setpt1 = 10;
    cyc(1);
    check("R5 jump ref_code", ref_code, 10);
    check("R5 neg_flag", neg_flag, 1);
    cyc(4);
    out_reached = 1; cyc(1); out_reached = 0;   // R6 release
    check("R6 released", neg_flag, 0);
    setpt1 = 4; out_reached = 1; cyc(1);        // R6 pulse on jump cycle ignored
    out_reached = 0; cyc(2);
    check("R6 still waiting", neg_flag, 1);
    setpt1 = 8; cyc(1);                         // R9 higher target ends wait
    check("R9 wait abandoned", neg_flag, 0);
    wait_ref(8);
    sel = 0; slew = 7;                          // R2 back to setpt0=20
    measure(BASE * 128);
    wait_ref(11);
    mode = 2'b01; cyc(2); sel = 1; cyc(2);      // R8 all combos
    mode = 2'b11; cyc(2); sel = 0; mode = 2'b00; cyc(2);
    slew = 1; setpt0 = 30;
    wait_ref(15);
    cyc(BASE * 2 - 1);
    setpt0 = 3;                                 // R9 reversal mid-ramp
    cyc(3);
    run = 0; cyc(2);                            // R1
    check("R1 run low ref_code", ref_code, 0);
    check("R1 run low neg_flag", neg_flag, 0);
    run = 1; setpt0 = 6; slew = 0;
    wait_ref(6);
    cyc(5);
    summary();
  end
endmodule